// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a processor's execution core and decides when a pending interrupt or a fault takes over the instruction stream. An ordinary interrupt request is only recorded as pending. The sequencer acts on it when the core reports that the current instruction has finished. A fault raised by the executing instruction does not wait. The sequencer tells the core at once to abandon that instruction, so a boundary is reached in the same cycle.

When it accepts a request, the sequencer captures three values from the core: the program counter, the return address and the condition codes. It does not save the general registers. It pushes this context onto an internal stack of eight entries. It then reads the handler address from a 16-entry vector table and gives the core a one-cycle redirect strobe with the new program counter. The vector table index combines a fixed base for each source with a small code that the peripheral supplies. Software fills the table through a write port.

When the core signals a return from interrupt, the most recent context is popped and handed back so that the core can resume. Entries can nest up to the depth of the stack. A push when the stack is full, or a return when it is empty, is refused and raises a flag.

Top module: `intr_sequencer`

## Requirements
- R1: While reset is active, redirect, abort_instr, resume_valid, stack_ovf and stack_unf are low. After reset, the context stack is empty and no request is pending.
- R2: A one-cycle pulse on irq_req[i] makes line i pending from the next cycle. A pending line is accepted only in a cycle where the sequencer is idle, instr_boundary is high, rti is low and no fault is outstanding. The line stays pending until it is accepted.
- R3: fault_req is acted on in the same cycle when the sequencer is idle and rti is low: abort_instr goes high in that cycle whatever instr_boundary is. A fault raised while the sequencer is busy is held and taken in the first idle cycle.
- R4: A fault, whether new or held, wins over pending interrupts. Among pending interrupt lines, the lowest-numbered line wins.
- R5: After the acceptance cycle there is one cycle each for save, table fetch and jump. redirect is high for exactly the one jump cycle, which is the third cycle after acceptance. No other request is accepted until the sequence ends.
- R6: The table index for interrupt line i is ((i+1) << 2) OR irq_pvec[2i+1:2i], with the code sampled in the acceptance cycle. For a fault, the index is fault_code (entries 0 to 3). redirect_pc equals the table entry at that index.
- R7: When vt_we is high at a clock edge, vt_wdata is written to table entry vt_waddr. Fetches at later edges use the new value.
- R8: The acceptance cycle captures cur_pc, cur_ret and cur_cc, and a later return gives back exactly these values.
- R9: rti in an idle cycle with a non-empty stack pops the most recent context (last in, first out). resume_valid is then high for one cycle, the next one, with resume_pc, resume_ret and resume_cc. rti wins over acceptance in that cycle. rti while a sequence is in progress is ignored.
- R10: The stack holds 8 contexts. If the stack is full during the save cycle, stack_ovf is high for that cycle, the stack is left unchanged, the request is consumed and no redirect follows.
- R11: rti in an idle cycle with an empty stack raises stack_unf in that cycle and gives no resume_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | NUM_SRC | One-cycle request pulses, one per line |
| irq_pvec | input | NUM_SRC*PVEC_W | Peripheral vector code for each line |
| fault_req | input | 1 | Fault caused by the executing instruction |
| fault_code | input | PVEC_W | Fault vector index |
| instr_boundary | input | 1 | Current instruction completes this cycle |
| abort_instr | output | 1 | Abandon the current instruction (fault taken) |
| cur_pc | input | PC_W | Current program counter |
| cur_ret | input | PC_W | Return address |
| cur_cc | input | CC_W | Condition codes |
| rti | input | 1 | Return-from-interrupt strobe |
| vt_we | input | 1 | Vector table write enable |
| vt_waddr | input | VT_AW | Vector table write index |
| vt_wdata | input | PC_W | Handler address to store |
| redirect | output | 1 | One-cycle jump strobe |
| redirect_pc | output | PC_W | Handler address |
| resume_valid | output | 1 | Restored context is valid |
| resume_pc | output | PC_W | Restored program counter |
| resume_ret | output | PC_W | Restored return address |
| resume_cc | output | CC_W | Restored condition codes |
| stack_ovf | output | 1 | Push refused because the stack is full |
| stack_unf | output | 1 | Return refused because the stack is empty |

## Verification
A wrong stack pointer or a corrupted stack entry stays hidden until a return. It then shows at the ports one cycle after rti, as the wrong resume values, a missing resume_valid, or a stack_unf or stack_ovf flag at the wrong time. By contrast, a fault in the pending bits, the priority or the index calculation shows up quickly: the redirect strobe lands on the wrong table entry three cycles after acceptance, or an abort comes in the wrong cycle. The bench models every cycle and compares all outputs on every clock, so the first wrong cycle is reported.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;
  parameter int PC_W = 16;
  parameter int CC_W = 4;

  typedef struct packed {
    logic [PC_W-1:0] pc;
    logic [PC_W-1:0] ret;
    logic [CC_W-1:0] cc;
  } ctx_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SAVE, ST_FETCH, ST_JUMP} seq_st_t;
endpackage

// File: rtl/intr_arbiter.sv
module intr_arbiter #(
  parameter int NUM_SRC = 3,
  parameter int PVEC_W  = 2,
  parameter int VT_AW   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        irq_req,
  input  logic [NUM_SRC*PVEC_W-1:0] irq_pvec,
  input  logic                      take,
  output logic                      any_pend,
  output logic [VT_AW-1:0]          win_idx
);
  logic [NUM_SRC-1:0] pend_q, pend_d, grant;
  logic [VT_AW-1:0]   term [NUM_SRC];

  // lowest-numbered pending line wins (loop runs downwards)
  always_comb begin
    grant = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pend_q[i]) grant = NUM_SRC'(1) << i;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int BASE = (g + 1) << PVEC_W;
    assign term[g] = grant[g] ? (VT_AW'(BASE) | VT_AW'(irq_pvec[g*PVEC_W +: PVEC_W])) : '0;
  end

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) win_idx = win_idx | term[i];
  end

  assign any_pend = |pend_q;
  assign pend_d   = (pend_q & ~(take ? grant : '0)) | irq_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_grant_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((grant & pend_q) != '0));
  p_taken_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ((grant & irq_req) == '0)) |=> ((pend_q & $past(grant)) == '0));
endmodule

// File: rtl/ctx_stack.sv
module ctx_stack
  import intr_seq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  input  ctx_t din,
  output logic full,
  output logic empty,
  output ctx_t top
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ctx_t             mem [DEPTH];
  logic [SP_W-1:0]  sp_q, sp_d;
  logic [IDX_W-1:0] top_idx;
  logic             do_push, do_pop;

  assign full    = (sp_q == SP_W'(DEPTH));
  assign empty   = (sp_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty & ~push;
  assign top_idx = IDX_W'(sp_q - SP_W'(1));
  assign top     = mem[top_idx];

  always_comb begin
    sp_d = sp_q;
    if (do_push)     sp_d = sp_q + SP_W'(1);
    else if (do_pop) sp_d = sp_q - SP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[IDX_W'(sp_q)] <= din;
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> $stable(sp_q));
  p_sp_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SP_W'(DEPTH));
  p_pop_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (sp_q == $past(sp_q) - SP_W'(1)));
endmodule

// File: rtl/vec_table.sv
module vec_table
  import intr_seq_pkg::*;
#(
  parameter int VT_AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [VT_AW-1:0] waddr,
  input  logic [PC_W-1:0]  wdata,
  input  logic [VT_AW-1:0] raddr,
  output logic [PC_W-1:0]  rdata
);
  localparam int ENTRIES = 1 << VT_AW;

  logic [PC_W-1:0] ent_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ent_q[g] <= '0;
      else if (we && waddr == VT_AW'(g))   ent_q[g] <= wdata;
    end
  end

  assign rdata = ent_q[raddr];
endmodule

// File: rtl/intr_sequencer.sv
module intr_sequencer
  import intr_seq_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int DEPTH   = 8,
  parameter int PVEC_W  = 2,
  localparam int VT_AW  = $clog2((NUM_SRC + 1) << PVEC_W)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        irq_req,
  input  logic [NUM_SRC*PVEC_W-1:0] irq_pvec,
  input  logic                      fault_req,
  input  logic [PVEC_W-1:0]         fault_code,
  input  logic                      instr_boundary,
  output logic                      abort_instr,
  input  logic [PC_W-1:0]           cur_pc,
  input  logic [PC_W-1:0]           cur_ret,
  input  logic [CC_W-1:0]           cur_cc,
  input  logic                      rti,
  input  logic                      vt_we,
  input  logic [VT_AW-1:0]          vt_waddr,
  input  logic [PC_W-1:0]           vt_wdata,
  output logic                      redirect,
  output logic [PC_W-1:0]           redirect_pc,
  output logic                      resume_valid,
  output logic [PC_W-1:0]           resume_pc,
  output logic [PC_W-1:0]           resume_ret,
  output logic [CC_W-1:0]           resume_cc,
  output logic                      stack_ovf,
  output logic                      stack_unf
);
  logic [1:0]        rsync_q;
  logic              rst_core_n;
  seq_st_t           st_q, st_d;
  logic              idle, fault_now, take_fault, take_irq, take;
  logic              fpend_q, fpend_d;
  logic [PVEC_W-1:0] fcode_q, fcode_sel;
  logic [VT_AW-1:0]  win_idx, sel_idx, idx_q;
  logic              any_pend, st_full, st_empty, push, pop;
  ctx_t              ctx_in, ctx_q, top_ctx, res_ctx_q;
  logic [PC_W-1:0]   vt_rdata, tgt_q;
  logic              res_v_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  assign idle       = (st_q == ST_IDLE);
  assign fault_now  = fault_req | fpend_q;
  assign take_fault = idle & ~rti & fault_now;
  assign take_irq   = idle & ~rti & ~fault_now & instr_boundary & any_pend;
  assign take       = take_fault | take_irq;
  assign fcode_sel  = fault_req ? fault_code : fcode_q;
  assign sel_idx    = take_fault ? VT_AW'(fcode_sel) : win_idx;
  assign push       = (st_q == ST_SAVE);
  assign pop        = idle & rti & ~st_empty;
  assign ctx_in     = '{pc: cur_pc, ret: cur_ret, cc: cur_cc};
  assign fpend_d    = take_fault ? 1'b0 : (fpend_q | fault_req);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (take) st_d = ST_SAVE;
      ST_SAVE:  st_d = st_full ? ST_IDLE : ST_FETCH;
      ST_FETCH: st_d = ST_JUMP;
      ST_JUMP:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q      <= ST_IDLE;
      fpend_q   <= 1'b0;
      fcode_q   <= '0;
      idx_q     <= '0;
      ctx_q     <= '0;
      tgt_q     <= '0;
      res_v_q   <= 1'b0;
      res_ctx_q <= '0;
    end else begin
      st_q    <= st_d;
      fpend_q <= fpend_d;
      res_v_q <= pop;
      if (fault_req)          fcode_q   <= fault_code;
      if (take)               idx_q     <= sel_idx;
      if (take)               ctx_q     <= ctx_in;
      if (st_q == ST_FETCH)   tgt_q     <= vt_rdata;
      if (pop)                res_ctx_q <= top_ctx;
    end
  end

  intr_arbiter #(.NUM_SRC(NUM_SRC), .PVEC_W(PVEC_W), .VT_AW(VT_AW)) u_arb (
    .clk(clk), .rst_n(rst_core_n), .irq_req(irq_req), .irq_pvec(irq_pvec),
    .take(take_irq), .any_pend(any_pend), .win_idx(win_idx));

  ctx_stack #(.DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_core_n), .push(push), .pop(pop), .din(ctx_q),
    .full(st_full), .empty(st_empty), .top(top_ctx));

  vec_table #(.VT_AW(VT_AW)) u_vt (
    .clk(clk), .rst_n(rst_core_n), .we(vt_we), .waddr(vt_waddr),
    .wdata(vt_wdata), .raddr(idx_q), .rdata(vt_rdata));

  assign abort_instr  = take_fault;
  assign redirect     = (st_q == ST_JUMP);
  assign redirect_pc  = tgt_q;
  assign resume_valid = res_v_q;
  assign resume_pc    = res_ctx_q.pc;
  assign resume_ret   = res_ctx_q.ret;
  assign resume_cc    = res_ctx_q.cc;
  assign stack_ovf    = push & st_full;
  assign stack_unf    = idle & rti & st_empty;

  p_redirect_pulse_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    redirect |=> !redirect);
  p_resume_follows_rti_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    resume_valid |-> $past(rti));
  p_unf_no_resume_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    stack_unf |=> !resume_valid);
  p_ovf_no_redirect_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    stack_ovf |=> !redirect);
  p_abort_starts_seq_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    abort_instr |=> !abort_instr);
endmodule

// File: tb/intr_sequencer_test.sv
module intr_sequencer_test;
  localparam int NS = 3;
  localparam int DP = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  irq_req;
  logic [5:0]  irq_pvec;
  logic        fault_req;
  logic [1:0]  fault_code;
  logic        instr_boundary;
  logic        abort_instr;
  logic [15:0] cur_pc, cur_ret;
  logic [3:0]  cur_cc;
  logic        rti, vt_we;
  logic [3:0]  vt_waddr;
  logic [15:0] vt_wdata;
  logic        redirect, resume_valid, stack_ovf, stack_unf;
  logic [15:0] redirect_pc, resume_pc, resume_ret;
  logic [3:0]  resume_cc;

  intr_sequencer uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_pvec(irq_pvec),
    .fault_req(fault_req), .fault_code(fault_code), .instr_boundary(instr_boundary),
    .abort_instr(abort_instr), .cur_pc(cur_pc), .cur_ret(cur_ret), .cur_cc(cur_cc),
    .rti(rti), .vt_we(vt_we), .vt_waddr(vt_waddr), .vt_wdata(vt_wdata),
    .redirect(redirect), .redirect_pc(redirect_pc), .resume_valid(resume_valid),
    .resume_pc(resume_pc), .resume_ret(resume_ret), .resume_cc(resume_cc),
    .stack_ovf(stack_ovf), .stack_unf(stack_unf));

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // reference model state
  int          m_st = 0;
  bit [2:0]    m_pend = '0;
  bit          m_fp = 1'b0;
  bit [1:0]    m_fc = '0;
  bit [3:0]    m_idx = '0;
  bit [35:0]   m_ctx = '0;
  bit [15:0]   m_tgt = '0;
  bit          m_rv = 1'b0;
  bit [35:0]   m_rctx = '0;
  bit [35:0]   m_stk[$];
  bit [15:0]   m_vt[16];

  task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic step();
    bit idle, fnow, tf, ti, full;
    int w;
    bit [15:0] new_tgt;
    #1;
    idle = (m_st == 0);
    fnow = fault_req || m_fp;
    tf   = idle && !rti && fnow;
    ti   = idle && !rti && !fnow && instr_boundary && (m_pend != 0);
    full = (m_stk.size() == DP);
    cmp("R3 R4 abort_instr", abort_instr, tf);
    cmp("R2 R5 redirect", redirect, m_st == 3);
    if (m_st == 3) cmp("R4 R6 R7 redirect_pc", redirect_pc, m_tgt);
    cmp("R10 stack_ovf", stack_ovf, (m_st == 1) && full);
    cmp("R11 stack_unf", stack_unf, idle && rti && m_stk.size() == 0);
    cmp("R9 resume_valid", resume_valid, m_rv);
    if (m_rv) cmp("R8 R9 resume context", {resume_pc, resume_ret, resume_cc}, m_rctx);
    @(posedge clk);
    new_tgt = m_vt[m_idx];
    if (vt_we) m_vt[vt_waddr] = vt_wdata;
    if (m_st == 2) m_tgt = new_tgt;
    m_rv = idle && rti && m_stk.size() > 0;
    if (m_rv) m_rctx = m_stk.pop_back();
    if (m_st == 1 && !full) m_stk.push_back(m_ctx);
    w = 0;
    for (int i = NS - 1; i >= 0; i--) if (m_pend[i]) w = i;
    if (tf) m_idx = fault_req ? {2'b00, fault_code} : {2'b00, m_fc};
    if (ti) begin
      m_idx = 4'((w + 1) << 2) | {2'b00, irq_pvec[w*2 +: 2]};
      m_pend[w] = 1'b0;
    end
    if (tf || ti) m_ctx = {cur_pc, cur_ret, cur_cc};
    m_pend = m_pend | irq_req;
    m_fp = tf ? 1'b0 : (m_fp | fault_req);
    if (fault_req) m_fc = fault_code;
    case (m_st)
      0: m_st = (tf || ti) ? 1 : 0;
      1: m_st = full ? 0 : 2;
      2: m_st = 3;
      default: m_st = 0;
    endcase
    @(negedge clk);
  endtask

  task automatic idle_n(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic fire(bit [2:0] m);
    irq_req = m; step(); irq_req = '0;
  endtask

  task automatic fault(bit [1:0] c);
    fault_req = 1'b1; fault_code = c; step(); fault_req = 1'b0;
  endtask

  task automatic ret();
    rti = 1'b1; step(); rti = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_req = '0; irq_pvec = '0; fault_req = 1'b0; fault_code = '0;
    instr_boundary = 1'b0; cur_pc = '0; cur_ret = '0; cur_cc = '0; rti = 1'b0;
    vt_we = 1'b0; vt_waddr = '0; vt_wdata = '0;
    for (int i = 0; i < 16; i++) m_vt[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    cmp("R1 redirect", redirect, 1'b0);
    cmp("R1 abort_instr", abort_instr, 1'b0);
    cmp("R1 resume_valid", resume_valid, 1'b0);
    cmp("R1 flags", {stack_ovf, stack_unf}, 2'b00);
    rst_n = 1'b1;
    idle_n(4);
    // R7: fill the vector table
    for (int i = 0; i < 16; i++) begin
      vt_we = 1'b1; vt_waddr = 4'(i); vt_wdata = 16'h1000 + 16'(i * 16'h0111);
      step();
    end
    vt_we = 1'b0;
    // R2: pending until boundary; R6 peripheral code
    irq_pvec = 6'b00_10_00; cur_pc = 16'h0200; cur_ret = 16'h0202; cur_cc = 4'h5;
    fire(3'b010);
    idle_n(3);
    instr_boundary = 1'b1; step(); instr_boundary = 1'b0;
    idle_n(5);
    // R4: lowest line first, then the other
    irq_pvec = 6'b11_00_01; cur_pc = 16'h0300; cur_ret = 16'h0304; cur_cc = 4'hA;
    fire(3'b101);
    instr_boundary = 1'b1; idle_n(10); instr_boundary = 1'b0;
    // R3 R4: fault wins over a pending interrupt, no boundary needed
    fire(3'b001);
    cur_pc = 16'h0400; cur_ret = 16'h0402; cur_cc = 4'h3;
    fault(2'd3);
    idle_n(4);
    instr_boundary = 1'b1; idle_n(6); instr_boundary = 1'b0;
    // R3: fault during a busy sequence is held
    fire(3'b100); instr_boundary = 1'b1; step(); instr_boundary = 1'b0;
    fault(2'd1);
    idle_n(8);
    // R9: rti ignored while busy, then LIFO returns
    fire(3'b010); instr_boundary = 1'b1; step(); instr_boundary = 1'b0;
    ret(); idle_n(4);
    for (int i = 0; i < 8; i++) begin ret(); idle_n(1); end
    // R11: empty stack
    ret(); ret();
    // R10: fill to 8 then overflow
    for (int i = 0; i < 9; i++) begin
      cur_pc = 16'h0500 + 16'(i); cur_ret = 16'h0600 + 16'(i); cur_cc = 4'(i);
      fault(2'(i)); idle_n(4);
    end
    for (int i = 0; i < 9; i++) ret();
    // R7: rewrite one entry, then use it
    vt_we = 1'b1; vt_waddr = 4'd2; vt_wdata = 16'hBEEF; step(); vt_we = 1'b0;
    fault(2'd2); idle_n(5); ret(); idle_n(2);
    // mixed pseudo-random phase
    for (int i = 0; i < 2000; i++) begin
      irq_req = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
      irq_pvec = 6'($urandom);
      fault_req = (($urandom % 20) == 0);
      fault_code = 2'($urandom);
      instr_boundary = 1'($urandom);
      rti = (($urandom % 6) == 0);
      cur_pc = 16'($urandom); cur_ret = 16'($urandom); cur_cc = 4'($urandom);
      vt_we = (($urandom % 10) == 0); vt_waddr = 4'($urandom); vt_wdata = 16'($urandom);
      step();
    end
    irq_req = '0; fault_req = 1'b0; rti = 1'b0; vt_we = 1'b0; instr_boundary = 1'b0;
    idle_n(6);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule